// File: doc/BRIEF.md
# Shared IRQ Flag Controller

This block keeps a bank of eight event flags that four small sequencer engines share. Each engine can issue a flag operation in any cycle. An operation carries a 5-bit index, a clear control and a wait control. The block turns the index into a flag number. In relative mode the engine's own number is folded into that flag number, so engines that run the same program reach different flags. The block then sets or clears the selected flag. All requests made in the same cycle are merged, and software can also clear flags through a write-1-to-clear input.

When an engine issues a set with wait, the block raises a per-engine stall output. The stall stays high until the selected flag has been seen cleared, and that is when the engine may go on. The engine's own post-operation delay count should start only after the stall drops. Flags 0 to 3 drive two registered interrupt lines, and each line has its own enable mask. Flags 4 to 7 are only visible to the engines.

Top module: `irq_flag_ctrl`

## Requirements
- R1: With index bit 4 clear, the flag number is index bits 2:0. Index bit 3 is ignored.
- R2: With index bit 4 set, flag bits 1:0 equal (index[1:0] + engine number) mod 4, and flag bit 2 equals index bit 2. For example, engine 2 with index 0x11 selects flag 3, and with index 0x13 selects flag 1.
- R3: An operation with the clear control low sets the selected flag. With the clear control high it clears the flag. The result appears on `flags_o` (bit n is flag n) after the clock edge on which the operation is presented.
- R4: Operations from several engines in one cycle all take effect. If a set and a clear hit the same flag in one cycle, the set wins.
- R5: `sw_clr_valid` with `sw_clr_mask` clears each flag 0 to 3 whose mask bit is 1 (mask bit n is flag n), in the same merge as engine operations. A set of the same flag in that cycle wins. Flags 4 to 7 are not affected.
- R6: A set with the wait control high raises `stalled_o[e]` on the same edge that sets the flag. The stall stays high while that flag is set. It falls on the first edge at which the flag was already clear before that edge, which is one cycle after the clearing edge.
- R7: `irq0_o` is the registered OR of `flags_o[3:0] & int_en0`, and `irq1_o` is the same with `int_en1`. Each is updated one edge after the flags.
- R8: Flags 4 to 7 never drive `irq0_o` or `irq1_o`.
- R9: Reset clears all flags, all stall outputs and both interrupt lines.
- R10: A clear operation with the wait control high does not stall its engine.
- R11: No flag changes in a cycle with no engine operation and no software clear.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 4 | One bit per engine: an operation is presented this cycle |
| op_index | input | 20 | 5-bit index per engine; engine e uses bits [5e+4:5e] |
| op_clear | input | 4 | Per engine: 1 clears the flag, 0 sets it |
| op_wait | input | 4 | Per engine: on a set, stall until the flag is cleared |
| sw_clr_valid | input | 1 | Software clear strobe |
| sw_clr_mask | input | 4 | Write-1-to-clear mask for flags 3:0 |
| int_en0 | input | 4 | Enable mask of interrupt line 0 |
| int_en1 | input | 4 | Enable mask of interrupt line 1 |
| flags_o | output | 8 | Current flag state |
| stalled_o | output | 4 | Per-engine stall; the engine may proceed when it is low |
| irq0_o | output | 1 | Interrupt line 0 |
| irq1_o | output | 1 | Interrupt line 1 |

## Verification
The index resolution is tested with absolute indices, including ones with bit 3 set to show that bit is ignored. It is also tested with relative indices on several engines, where the modulo-4 wrap and the untouched bit 2 separate a correct adder from a full-width or unwrapped one. Clears hit both flags that are set and flags that are already clear.

Merging is tested with these same-cycle cases:
- a set and a clear on one flag from different engines;
- a set racing a software clear;
- several independent sets at once.

Each case shows whether set priority and the OR-merge hold.

The stall is tested with an engine clear and with a software clear, using absolute and relative indices. The checks sample exactly at the cycle the flag drops and at the cycle after it. A clear-with-wait is also issued to show it never stalls.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  parameter int unsigned NUM_ENG   = 4;
  parameter int unsigned NUM_FLAGS = 8;
  parameter int unsigned IDX_W     = 5;
  parameter int unsigned EXT_FLAGS = 4;
  localparam int unsigned FLAG_W   = $clog2(NUM_FLAGS);
  localparam int unsigned ENG_W    = $clog2(NUM_ENG);
endpackage

// File: rtl/irqf_resolve.sv
module irqf_resolve
  import irqf_pkg::*;
#(
  parameter int unsigned ENG_ID = 0
) (
  input  logic                 op_valid,
  input  logic [IDX_W-1:0]     op_index,
  input  logic                 op_clear,
  output logic [FLAG_W-1:0]    flag_num,
  output logic [NUM_FLAGS-1:0] set_vec,
  output logic [NUM_FLAGS-1:0] clr_vec
);
  localparam logic [ENG_W-1:0] ID_LO = ENG_W'(ENG_ID);

  logic [ENG_W-1:0] low_bits;
  logic             unused_idx_bits;

  assign unused_idx_bits = ^op_index[IDX_W-2:FLAG_W];

  always_comb begin
    low_bits = op_index[ENG_W-1:0];
    if (op_index[IDX_W-1]) begin
      low_bits = op_index[ENG_W-1:0] + ID_LO;
    end
    flag_num = {op_index[FLAG_W-1:ENG_W], low_bits};
  end

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (op_valid) begin
      if (op_clear) begin
        clr_vec[flag_num] = 1'b1;
      end else begin
        set_vec[flag_num] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank
  import irqf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_all,
  input  logic [NUM_FLAGS-1:0] clr_all,
  output logic [NUM_FLAGS-1:0] flags_q
);
  logic [NUM_FLAGS-1:0] flags_d;
  logic                 upd_en;

  always_comb begin
    upd_en  = (|set_all) | (|clr_all);
    flags_d = (flags_q & ~clr_all) | set_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/irqf_stall.sv
module irqf_stall
  import irqf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FLAG_W-1:0]    start_flag,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 stalled
);
  logic              stall_d;
  logic [FLAG_W-1:0] wflag_q;
  logic [FLAG_W-1:0] wflag_d;
  logic              stall_en;

  always_comb begin
    stall_d  = stalled;
    wflag_d  = wflag_q;
    stall_en = 1'b0;
    if (start) begin
      stall_d  = 1'b1;
      wflag_d  = start_flag;
      stall_en = 1'b1;
    end else if (stalled && !flags[wflag_q]) begin
      stall_d  = 1'b0;
      stall_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stalled <= 1'b0;
      wflag_q <= '0;
    end else if (stall_en) begin
      stalled <= stall_d;
      wflag_q <= wflag_d;
    end
  end
endmodule

// File: rtl/irqf_irq_out.sv
module irqf_irq_out
  import irqf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EXT_FLAGS-1:0] flags_lo,
  input  logic [EXT_FLAGS-1:0] en0,
  input  logic [EXT_FLAGS-1:0] en1,
  output logic                 irq0,
  output logic                 irq1
);
  logic irq0_d;
  logic irq1_d;

  always_comb begin
    irq0_d = |(flags_lo & en0);
    irq1_d = |(flags_lo & en1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      irq0 <= irq0_d;
      irq1 <= irq1_d;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ENG-1:0]       op_valid,
  input  logic [NUM_ENG*IDX_W-1:0] op_index,
  input  logic [NUM_ENG-1:0]       op_clear,
  input  logic [NUM_ENG-1:0]       op_wait,
  input  logic                     sw_clr_valid,
  input  logic [EXT_FLAGS-1:0]     sw_clr_mask,
  input  logic [EXT_FLAGS-1:0]     int_en0,
  input  logic [EXT_FLAGS-1:0]     int_en1,
  output logic [NUM_FLAGS-1:0]     flags_o,
  output logic [NUM_ENG-1:0]       stalled_o,
  output logic                     irq0_o,
  output logic                     irq1_o
);
  logic [NUM_FLAGS-1:0] set_vec  [NUM_ENG];
  logic [NUM_FLAGS-1:0] clr_vec  [NUM_ENG];
  logic [FLAG_W-1:0]    flag_num [NUM_ENG];
  logic [NUM_FLAGS-1:0] set_all;
  logic [NUM_FLAGS-1:0] clr_all;

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    irqf_resolve #(.ENG_ID(e)) u_res (
      .op_valid (op_valid[e]),
      .op_index (op_index[e*IDX_W +: IDX_W]),
      .op_clear (op_clear[e]),
      .flag_num (flag_num[e]),
      .set_vec  (set_vec[e]),
      .clr_vec  (clr_vec[e])
    );

    irqf_stall u_stall (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (op_valid[e] & op_wait[e] & ~op_clear[e]),
      .start_flag (flag_num[e]),
      .flags      (flags_o),
      .stalled    (stalled_o[e])
    );
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int e = 0; e < NUM_ENG; e++) begin
      set_all |= set_vec[e];
      clr_all |= clr_vec[e];
    end
    if (sw_clr_valid) begin
      clr_all[EXT_FLAGS-1:0] |= sw_clr_mask;
    end
  end

  irqf_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_all (set_all),
    .clr_all (clr_all),
    .flags_q (flags_o)
  );

  irqf_irq_out u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags_lo (flags_o[EXT_FLAGS-1:0]),
    .en0      (int_en0),
    .en1      (int_en1),
    .irq0     (irq0_o),
    .irq1     (irq1_o)
  );
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker
  import irqf_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_ENG-1:0]       op_valid,
  input logic [NUM_ENG-1:0]       op_clear,
  input logic [NUM_ENG-1:0]       op_wait,
  input logic                     sw_clr_valid,
  input logic [EXT_FLAGS-1:0]     sw_clr_mask,
  input logic [EXT_FLAGS-1:0]     int_en0,
  input logic [EXT_FLAGS-1:0]     int_en1,
  input logic [NUM_FLAGS-1:0]     flags_o,
  input logic [NUM_ENG-1:0]       stalled_o,
  input logic                     irq0_o,
  input logic                     irq1_o
);
  // R7
  irq0_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq0_o == $past(|(flags_o[EXT_FLAGS-1:0] & int_en0))));

  // R7
  irq1_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq1_o == $past(|(flags_o[EXT_FLAGS-1:0] & int_en1))));

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|op_valid) && !sw_clr_valid) |=> $stable(flags_o));

  // R5
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_valid && !(|op_valid)) |=>
      ((flags_o[EXT_FLAGS-1:0] & $past(sw_clr_mask)) == '0));

  // R5
  sw_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_valid && !(|op_valid)) |=>
      (flags_o[NUM_FLAGS-1:EXT_FLAGS] == $past(flags_o[NUM_FLAGS-1:EXT_FLAGS])));

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_chk
    // R6 R10
    stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stalled_o[e]) |-> $past(op_valid[e] && op_wait[e] && !op_clear[e]));

    // R6
    stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid[e] && op_wait[e] && !op_clear[e]) |=> stalled_o[e]);
  end
endmodule

bind irq_flag_ctrl irqf_checker u_irqf_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_clear     (op_clear),
  .op_wait      (op_wait),
  .sw_clr_valid (sw_clr_valid),
  .sw_clr_mask  (sw_clr_mask),
  .int_en0      (int_en0),
  .int_en1      (int_en1),
  .flags_o      (flags_o),
  .stalled_o    (stalled_o),
  .irq0_o       (irq0_o),
  .irq1_o       (irq1_o)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_valid;
  logic [19:0] op_index;
  logic [3:0]  op_clear;
  logic [3:0]  op_wait;
  logic        sw_clr_valid;
  logic [3:0]  sw_clr_mask;
  logic [3:0]  int_en0;
  logic [3:0]  int_en1;
  logic [7:0]  flags_o;
  logic [3:0]  stalled_o;
  logic        irq0_o;
  logic        irq1_o;

  int checks;
  int errors;
  bit done;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_index(op_index),
    .op_clear(op_clear), .op_wait(op_wait), .sw_clr_valid(sw_clr_valid),
    .sw_clr_mask(sw_clr_mask), .int_en0(int_en0), .int_en1(int_en1),
    .flags_o(flags_o), .stalled_o(stalled_o), .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {engine[1:0], index[4:0], clear, expected flags[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {2'd2, 5'h11, 1'b0, 8'h08},  // R2 engine 2, 0x11 -> flag 3
    {2'd2, 5'h13, 1'b0, 8'h0A},  // R2 engine 2, 0x13 -> flag 1
    {2'd1, 5'h0E, 1'b0, 8'h4A},  // R1 bit 3 ignored -> flag 6
    {2'd3, 5'h15, 1'b0, 8'h5A},  // R2 wrap, bit 2 kept -> flag 4
    {2'd0, 5'h10, 1'b0, 8'h5B},  // R2 engine 0 -> flag 0
    {2'd1, 5'h03, 1'b1, 8'h53},  // R3 clear flag 3
    {2'd3, 5'h11, 1'b1, 8'h52},  // R2 engine 3 clear -> flag 0
    {2'd0, 5'h07, 1'b0, 8'hD2}   // R1 flag 7
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = '0; op_index = '0; op_clear = '0; op_wait = '0;
    sw_clr_valid = 1'b0; sw_clr_mask = '0;
  endtask

  // present one cycle of stimulus, return at the negedge after the edge
  task automatic cyc(input logic [3:0] v, input logic [19:0] idx, input logic [3:0] c,
                     input logic [3:0] w, input logic sv, input logic [3:0] sm);
    @(negedge clk);
    op_valid = v; op_index = idx; op_clear = c; op_wait = w;
    sw_clr_valid = sv; sw_clr_mask = sm;
    @(negedge clk);
    idle();
  endtask

  task automatic clear_all();
    cyc(4'hF, {5'h07, 5'h06, 5'h05, 5'h04}, 4'hF, 4'h0, 1'b1, 4'hF);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    idle();
    int_en0 = '0; int_en1 = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 flags", flags_o, 8'h00);
    chk("R9 stall", {4'h0, stalled_o}, 8'h00);
    chk("R9 irq", {6'h0, irq1_o, irq0_o}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [1:0] e;
      logic [19:0] idx;
      e = VEC[i][15:14];
      idx = '0;
      idx[e*5 +: 5] = VEC[i][13:9];
      cyc(4'b0001 << e, idx, {3'b0, VEC[i][8]} << e, 4'h0, 1'b0, 4'h0);
      chk($sformatf("R1/R2/R3 vec %0d", i), flags_o, VEC[i][7:0]);
    end

    // R11: idle cycles leave flags untouched
    repeat (2) @(negedge clk);
    chk("R11 idle hold", flags_o, 8'hD2);

    // R4: set and clear of flag 5 together, plus sets of 2 and 3
    clear_all();
    chk("R4 cleared", flags_o, 8'h00);
    cyc(4'hF, {5'h03, 5'h02, 5'h05, 5'h05}, 4'b0010, 4'h0, 1'b0, 4'h0);
    chk("R4 merge set wins", flags_o, 8'h2C);
    cyc(4'b0001, {15'h0, 5'h07}, 4'h0, 4'h0, 1'b0, 4'h0);

    // R5: sw clear of all low flags racing a set of flag 1
    cyc(4'b0001, {15'h0, 5'h01}, 4'h0, 4'h0, 1'b1, 4'hF);
    chk("R5 sw clear set wins", flags_o, 8'hA2);

    // R7: registered interrupt lines
    clear_all();
    int_en0 = 4'b0010; int_en1 = 4'b0100;
    cyc(4'b0001, {15'h0, 5'h01}, 4'h0, 4'h0, 1'b0, 4'h0);
    chk("R7 lag irq", {6'h0, irq1_o, irq0_o}, 8'h00);
    @(negedge clk);
    chk("R7 irq0 on", {6'h0, irq1_o, irq0_o}, 8'h01);
    cyc(4'b0001, {15'h0, 5'h02}, 4'h0, 4'h0, 1'b0, 4'h0);
    @(negedge clk);
    chk("R7 both on", {6'h0, irq1_o, irq0_o}, 8'h03);

    // R8: upper flags never reach the lines
    clear_all();
    int_en0 = 4'hF; int_en1 = 4'hF;
    cyc(4'hF, {5'h07, 5'h06, 5'h05, 5'h04}, 4'h0, 4'h0, 1'b0, 4'h0);
    repeat (2) @(negedge clk);
    chk("R8 flags", flags_o, 8'hF0);
    chk("R8 irq low", {6'h0, irq1_o, irq0_o}, 8'h00);

    // R6: engine 1 waits on flag 6, engine 0 clears it
    clear_all();
    cyc(4'b0010, {10'h0, 5'h06, 5'h0}, 4'h0, 4'b0010, 1'b0, 4'h0);
    chk("R6 stall rises", {4'h0, stalled_o}, 8'h02);
    chk("R6 flag set", flags_o, 8'h40);
    repeat (3) @(negedge clk);
    chk("R6 stall holds", {4'h0, stalled_o}, 8'h02);
    cyc(4'b0001, {15'h0, 5'h06}, 4'b0001, 4'h0, 1'b0, 4'h0);
    chk("R6 stall at clear edge", {4'h0, stalled_o}, 8'h02);
    @(negedge clk);
    chk("R6 stall drops", {4'h0, stalled_o}, 8'h00);

    // R6 relative: engine 3 waits on 0x10 -> flag 3, software clears it
    cyc(4'b1000, {5'h10, 15'h0}, 4'h0, 4'b1000, 1'b0, 4'h0);
    chk("R6 rel flag", flags_o, 8'h08);
    chk("R6 rel stall", {4'h0, stalled_o}, 8'h08);
    cyc(4'h0, 20'h0, 4'h0, 4'h0, 1'b1, 4'b1000);
    chk("R6 rel still", {4'h0, stalled_o}, 8'h08);
    @(negedge clk);
    chk("R6 rel drops", {4'h0, stalled_o}, 8'h00);

    // R10: clear with wait never stalls
    cyc(4'b0100, {5'h0, 5'h02, 10'h0}, 4'b0100, 4'b0100, 1'b0, 4'h0);
    chk("R10 no stall", {4'h0, stalled_o}, 8'h00);
    @(negedge clk);
    chk("R10 still none", {4'h0, stalled_o}, 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule